// File: doc/BRIEF.md
# Timer Channel Interrupt Request Generator

This block turns the activity of one PWM/timer channel into a one-clock interrupt request. It watches the channel's output waveform, its run/stop status, an external start/stop pin and the channel's own reset line. A 2-bit mode field and an enable bit select which of these events raise the request.

The four modes are: counter stop, rising output edge, falling output edge, and both edges. The edge logic reproduces several quirks that software written for this kind of timer expects:

- Starting the counter counts as a rising edge.
- The first edge interrupt after a start is swallowed when the compare setting is degenerate: zero, all ones, or below the reload value.
- In stop mode, a low level on the external start/stop pin interrupts even when the channel is off.
- In falling-edge mode, a channel reset interrupts.

The counter, interrupt acknowledge and priority handling are outside the block.

Top module: `tmr_irq_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `irqReq` stays low.
- R2: Mode 2'b01 with `irqEn`=1: a 0→1 change of `tmrOut` between two clock samples makes `irqReq` high for exactly the one cycle following the sample that shows the new value.
- R3: Mode 2'b10 with `irqEn`=1: a 1→0 change of `tmrOut` gives a one-cycle pulse with the same timing as R2.
- R4: Mode 2'b11 with `irqEn`=1: both changes of `tmrOut` give a pulse each.
- R5: Mode 2'b00 with `irqEn`=1: a 1→0 change of `tmrRun` (counter stop) gives a one-cycle pulse.
- R6: In modes 2'b01 and 2'b11, a 0→1 change of `tmrRun` (start) is treated as a rising edge and gives a pulse.
- R7: The first edge event after a start gives no pulse when `cmpVal` is 0, is all ones (255 at 8 bits), or is below `rldVal`. Edge events after it fire normally. `cmpVal` equal to `rldVal` is not degenerate.
- R8: With `irqEn`=0, no event gives a pulse, except those of R9 and R10.
- R9: Mode 2'b00 with `startFromPin`=1: a high→low change of `startPin` gives a pulse three clock edges after the change, whatever `irqEn` and `tmrRun` are. With `startFromPin`=0 the pin has no effect.
- R10: Mode 2'b10: a 0→1 change of `chanRst` gives a pulse on the next cycle, whatever `irqEn` is.
- R11: An event not selected by the mode gives no pulse. For example, an output fall or a counter stop in mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrOut | input | 1 | Channel output waveform |
| tmrRun | input | 1 | Channel counting (1) or stopped (0) |
| startPin | input | 1 | External start/stop pin, asynchronous |
| startFromPin | input | 1 | 1 when start/stop is taken from the pin |
| chanRst | input | 1 | Channel reset, active high |
| cmpVal | input | CntWidth | Current compare value |
| rldVal | input | CntWidth | Current reload value |
| irqMode | input | 2 | 00 stop, 01 rise, 10 fall, 11 both |
| irqEn | input | 1 | Interrupt enable |
| irqReq | output | 1 | One-cycle interrupt request |

## Verification
The bench aims at the start-as-rising-edge rule. A design that got it wrong would miss the first interrupt after a start, or raise it in falling mode as well. It covers each of the three degenerate compare cases and the equal-compare boundary: an error there either swallows a legitimate first interrupt or lets a spurious one through, and in falling mode a swallowed first edge must not also eat the second. The two enable-independent exceptions are run with the enable cleared. The pin case also has the source select cleared, which would catch a pin that leaks into other modes, a missing synchronizer delay, or a level that repeats the pulse every cycle.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  typedef enum logic [1:0] {
    IRQ_ON_STOP = 2'b00,
    IRQ_ON_RISE = 2'b01,
    IRQ_ON_FALL = 2'b10,
    IRQ_ON_BOTH = 2'b11
  } irqMode_e;

  // Events seen by the datapath this cycle
  typedef struct packed {
    logic outRise;
    logic outFall;
    logic runStart;
    logic runStop;
    logic pinFall;
    logic chanRstRise;
    logic degenerate;
    logic firstWin;
  } tmrEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic armFirst;
    logic disarmFirst;
  } irqStrobe_t;

endpackage

// File: rtl/tmr_irq_sync.sv
module tmr_irq_sync #(
  parameter int   Stages   = 2,
  parameter logic ResetVal = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [Stages-1:0] chainQ;

  generate
    if (Stages == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {Stages{ResetVal}};
        else       chainQ <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {Stages{ResetVal}};
        else       chainQ <= {chainQ[Stages-2:0], din};
      end
    end
  endgenerate

  assign dout = chainQ[Stages-1];

endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int CntWidth   = 8,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tmrOut,
  input  logic                tmrRun,
  input  logic                startPin,
  input  logic                chanRst,
  input  logic [CntWidth-1:0] cmpVal,
  input  logic [CntWidth-1:0] rldVal,
  input  irqStrobe_t          strobe,
  output tmrEvt_t             evt,
  output logic                irqReq
);

  localparam logic [CntWidth-1:0] CntZero = '0;
  localparam logic [CntWidth-1:0] CntTop  = {CntWidth{1'b1}};

  logic pinSync;
  logic outQ, runQ, pinQ, chanRstQ;
  logic pendingQ;
  logic irqQ;

  tmr_irq_sync #(.Stages(SyncStages), .ResetVal(1'b1)) u_pinSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (startPin),
    .dout (pinSync)
  );

  // Previous-cycle samples used for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= 1'b0;
      runQ     <= 1'b0;
      pinQ     <= 1'b1;
      chanRstQ <= 1'b1;
    end else begin
      outQ     <= tmrOut;
      runQ     <= tmrRun;
      pinQ     <= pinSync;
      chanRstQ <= chanRst;
    end
  end

  // First-event window after a start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pendingQ <= 1'b0;
    else if (strobe.disarmFirst) pendingQ <= 1'b0;
    else if (strobe.armFirst)    pendingQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.fire;
  end

  always_comb begin
    evt.outRise     = tmrOut & ~outQ;
    evt.outFall     = ~tmrOut & outQ;
    evt.runStart    = tmrRun & ~runQ;
    evt.runStop     = ~tmrRun & runQ;
    evt.pinFall     = ~pinSync & pinQ;
    evt.chanRstRise = chanRst & ~chanRstQ;
    evt.degenerate  = (cmpVal == CntZero) || (cmpVal == CntTop) || (cmpVal < rldVal);
    evt.firstWin    = pendingQ | evt.runStart;
  end

  assign irqReq = irqQ;

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tmr_irq_pkg::*;
(
  input  irqMode_e   modeSel,
  input  logic       irqEn,
  input  logic       startFromPin,
  input  tmrEvt_t    evt,
  output irqStrobe_t strobe
);

  logic riseSel, fallSel;
  logic edgeEv, stopEv, pinEv, rstEv, swallow;

  always_comb begin
    riseSel = (modeSel == IRQ_ON_RISE) || (modeSel == IRQ_ON_BOTH);
    fallSel = (modeSel == IRQ_ON_FALL) || (modeSel == IRQ_ON_BOTH);

    // Start acts as a rising edge
    edgeEv  = irqEn & ((riseSel & (evt.outRise | evt.runStart)) |
                       (fallSel & evt.outFall));
    stopEv  = irqEn & (modeSel == IRQ_ON_STOP) & evt.runStop;
    // Exceptions that ignore the enable
    pinEv   = (modeSel == IRQ_ON_STOP) & startFromPin & evt.pinFall;
    rstEv   = (modeSel == IRQ_ON_FALL) & evt.chanRstRise;

    swallow = edgeEv & evt.firstWin & evt.degenerate;

    strobe.fire        = (edgeEv & ~swallow) | stopEv | pinEv | rstEv;
    strobe.armFirst    = evt.runStart & ~edgeEv;
    strobe.disarmFirst = edgeEv | evt.runStop;
  end

endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen
  import tmr_irq_pkg::*;
#(
  parameter int CntWidth   = 8,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tmrOut,
  input  logic                tmrRun,
  input  logic                startPin,
  input  logic                startFromPin,
  input  logic                chanRst,
  input  logic [CntWidth-1:0] cmpVal,
  input  logic [CntWidth-1:0] rldVal,
  input  logic [1:0]          irqMode,
  input  logic                irqEn,
  output logic                irqReq
);

  irqMode_e   modeSel;
  tmrEvt_t    evt;
  irqStrobe_t strobe;

  assign modeSel = irqMode_e'(irqMode);

  tmr_irq_dp #(.CntWidth(CntWidth), .SyncStages(SyncStages)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tmrOut   (tmrOut),
    .tmrRun   (tmrRun),
    .startPin (startPin),
    .chanRst  (chanRst),
    .cmpVal   (cmpVal),
    .rldVal   (rldVal),
    .strobe   (strobe),
    .evt      (evt),
    .irqReq   (irqReq)
  );

  tmr_irq_ctl u_ctl (
    .modeSel      (modeSel),
    .irqEn        (irqEn),
    .startFromPin (startFromPin),
    .evt          (evt),
    .strobe       (strobe)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !irqReq);

  p_rise_fires_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqEn && modeSel == IRQ_ON_RISE && evt.outRise && !evt.degenerate |=> irqReq);

  p_fall_fires_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqEn && modeSel == IRQ_ON_FALL && evt.outFall && !evt.degenerate |=> irqReq);

  p_both_fires_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqEn && modeSel == IRQ_ON_BOTH && (evt.outRise || evt.outFall) && !evt.degenerate
    |=> irqReq);

  p_stop_fires_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqEn && modeSel == IRQ_ON_STOP && evt.runStop |=> irqReq);

  p_start_fires_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqEn && (modeSel == IRQ_ON_RISE || modeSel == IRQ_ON_BOTH) && evt.runStart
    && !evt.degenerate |=> irqReq);

  p_first_swallowed_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == IRQ_ON_RISE && evt.runStart && evt.degenerate |=> !irqReq);

  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn && !(modeSel == IRQ_ON_STOP && startFromPin && evt.pinFall)
    && !(modeSel == IRQ_ON_FALL && evt.chanRstRise) |=> !irqReq);

  p_pin_fires_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == IRQ_ON_STOP && startFromPin && evt.pinFall |=> irqReq);

  p_chanrst_fires_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == IRQ_ON_FALL && evt.chanRstRise |=> irqReq);

  p_wrong_event_r11: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == IRQ_ON_RISE && !evt.outRise && !evt.runStart |=> !irqReq);

endmodule

// File: tb/tmr_irq_gen_bench.sv
`timescale 1ns/1ps
module tmr_irq_gen_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tmrOut, tmrRun, startPin, startFromPin, chanRst, irqEn;
  logic [7:0] cmpVal, rldVal;
  logic [1:0] irqMode;
  logic       irqReq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_gen u_tmr_irq_gen (
    .clk(clk), .rstN(rstN), .tmrOut(tmrOut), .tmrRun(tmrRun),
    .startPin(startPin), .startFromPin(startFromPin), .chanRst(chanRst),
    .cmpVal(cmpVal), .rldVal(rldVal), .irqMode(irqMode), .irqEn(irqEn),
    .irqReq(irqReq)
  );

  // {req[3:0], mode[1:0], en, tout, run, cmp[7:0], rld[7:0], expIrq}
  function automatic logic [25:0] mk(input int r, input logic [1:0] m,
                                     input logic e, input logic t, input logic u,
                                     input logic [7:0] c, input logic [7:0] l,
                                     input logic x);
    return {r[3:0], m, e, t, u, c, l, x};
  endfunction

  localparam int NumVec = 29;
  localparam logic [25:0] VEC [NumVec] = '{
    mk(1,  2'b01, 1, 0, 0, 128, 0, 0),   // R1 idle after reset
    mk(6,  2'b01, 1, 0, 1, 128, 0, 1),   // R6 start as rise
    mk(2,  2'b01, 1, 1, 1, 128, 0, 1),   // R2 rise
    mk(2,  2'b01, 1, 1, 1, 128, 0, 0),   // R2 single pulse
    mk(11, 2'b01, 1, 0, 1, 128, 0, 0),   // R11 fall in rise mode
    mk(3,  2'b10, 1, 0, 1, 128, 0, 0),
    mk(11, 2'b10, 1, 1, 1, 128, 0, 0),   // R11 rise in fall mode
    mk(3,  2'b10, 1, 0, 1, 128, 0, 1),   // R3 fall
    mk(4,  2'b11, 1, 1, 1, 128, 0, 1),   // R4 rise
    mk(4,  2'b11, 1, 0, 1, 128, 0, 1),   // R4 fall
    mk(8,  2'b11, 0, 1, 1, 128, 0, 0),   // R8 disabled
    mk(8,  2'b11, 0, 0, 1, 128, 0, 0),   // R8 disabled
    mk(5,  2'b00, 1, 0, 1, 128, 0, 0),
    mk(5,  2'b00, 1, 0, 0, 128, 0, 1),   // R5 stop
    mk(5,  2'b00, 1, 0, 0, 128, 0, 0),
    mk(7,  2'b01, 1, 0, 0, 0,   0, 0),
    mk(7,  2'b01, 1, 0, 1, 0,   0, 0),   // R7 cmp zero swallows start
    mk(7,  2'b01, 1, 1, 1, 0,   0, 1),   // R7 next edge fires
    mk(11, 2'b01, 1, 0, 0, 0,   0, 0),   // R11 stop in rise mode
    mk(7,  2'b10, 1, 0, 0, 255, 0, 0),
    mk(7,  2'b10, 1, 1, 1, 255, 0, 0),
    mk(7,  2'b10, 1, 0, 1, 255, 0, 0),   // R7 cmp top swallows first fall
    mk(7,  2'b10, 1, 1, 1, 255, 0, 0),
    mk(7,  2'b10, 1, 0, 1, 255, 0, 1),   // R7 second fall fires
    mk(7,  2'b11, 1, 0, 0, 10,  20, 0),
    mk(7,  2'b11, 1, 0, 1, 10,  20, 0),  // R7 cmp below reload
    mk(7,  2'b11, 1, 0, 0, 20,  20, 0),
    mk(7,  2'b11, 1, 0, 1, 20,  20, 1),  // R7 cmp equal reload fires
    mk(11, 2'b01, 1, 0, 1, 20,  20, 0)
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp, input string what);
    testCnt++;
    if (irqReq !== exp) begin
      failCnt++;
      $display("FAIL %s %s: irqReq=%b expected %b", req, what, irqReq, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: irqReq=%b expected completion", irqReq);
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; tmrOut = 1'b1; tmrRun = 1'b1; startPin = 1'b1;
    startFromPin = 1'b0; chanRst = 1'b0; irqEn = 1'b1;
    cmpVal = 8'd128; rldVal = 8'd0; irqMode = 2'b11;

    // R1: quiet in reset
    for (int i = 0; i < 3; i++) begin
      tmrOut = ~tmrOut;
      step();
      check("R1", 1'b0, "in reset");
    end
    tmrOut = 1'b0; tmrRun = 1'b0; irqMode = 2'b01;
    step();
    rstN = 1'b1;
    step();
    check("R1", 1'b0, "first cycle after reset");

    // Table walk
    for (int i = 0; i < NumVec; i++) begin
      logic [25:0] v;
      v = VEC[i];
      irqMode = v[21:20];
      irqEn   = v[19];
      tmrOut  = v[18];
      tmrRun  = v[17];
      cmpVal  = v[16:9];
      rldVal  = v[8:1];
      step();
      check($sformatf("R%0d", v[25:22]), v[0], $sformatf("table step %0d", i));
    end

    // R9: pin low level fires in stop mode with enable cleared and timer off
    irqMode = 2'b00; irqEn = 1'b0; tmrRun = 1'b0; tmrOut = 1'b0;
    startFromPin = 1'b1; startPin = 1'b1;
    repeat (3) step();
    startPin = 1'b0;
    step(); check("R9", 1'b0, "pin sync stage 1");
    step(); check("R9", 1'b0, "pin sync stage 2");
    step(); check("R9", 1'b1, "pin low fires");
    step(); check("R9", 1'b0, "held low single pulse");
    startPin = 1'b1;
    repeat (4) step();
    startFromPin = 1'b0;
    step();
    startPin = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R9", 1'b0, "pin ignored when source is internal");
    end
    startPin = 1'b1;
    repeat (4) step();

    // R10: channel reset in falling mode, enable cleared
    irqMode = 2'b10; irqEn = 1'b0;
    step();
    chanRst = 1'b1;
    step(); check("R10", 1'b1, "channel reset fires");
    step(); check("R10", 1'b0, "channel reset single pulse");
    chanRst = 1'b0;
    irqMode = 2'b01;
    step();
    chanRst = 1'b1;
    step(); check("R8", 1'b0, "channel reset in rise mode disabled");
    chanRst = 1'b0;
    step();

    done = 1;
    finishRun();
  end

endmodule